// File: doc/BRIEF.md
# Stochastic Weighted-Pairing Inner Product

This block merges seven bipolar stochastic bit-streams into one stream that carries their coefficient-weighted sum, divided by the sum of absolute coefficient values. It does this without any binary multiplier or adder. In bipolar coding a value s in [-1, 1] is a stream whose probability of a 1 is (s+1)/2. Each tap bit is first XORed with its coefficient sign bit, which negates the tap value. The seven results then enter a three-level tree of 2-to-1 multiplexers. A multiplexer whose select stream has probability w yields w·A + (1−w)·B.

The tree follows the symmetry of a linear-phase sixth-order filter:
- The outermost taps pair first, as (0,6), (1,5) and (2,4), while the centre tap waits.
- At the next level, pair (0,6) merges with pair (1,5), and pair (2,4) merges with the centre tap.
- The root merges those two results.

Symmetric coefficients are equal, so the three first-level multiplexers share one half-probability select stream.

Each of the four select streams comes from a stored 9-bit threshold compared against an 8-bit random word supplied on every cycle. Software-free loading of the thresholds uses a simple write strobe. The output bit is registered once. One result spans 256 cycles at 8-bit precision, and the surrounding logic generates and decodes the streams.

Top module: `sc_pair_tree_ip`

## Requirements
- R1: Each tap bit is XORed with its sign bit before entering the tree, so a sign of 1 inverts that tap's contribution.
- R2: The three first-level multiplexers share select stream 0. A select of 1 passes tap i and a select of 0 passes tap 6−i, for i = 0, 1, 2.
- R3: Select stream 1 picks pair (0,6) when 1 and pair (1,5) when 0. Select stream 2 picks pair (2,4) when 1 and the centre tap 3 when 0.
- R4: Select stream 3 (root) picks the stream-1 result when 1 and the stream-2 result when 0.
- R5: Select bit k is 1 exactly when the unsigned random word in `rnd_words[8k+7:8k]` is strictly below threshold k. A threshold of 0 gives constant 0 and a threshold of 256 or above gives constant 1. Over the 256 distinct random values, the number of 1s equals the threshold.
- R6: When `thr_wr_en` is 1 at a rising edge, `thr_wr_val` is stored in threshold `thr_wr_idx` (0 = shared first level, 1 = outer second level, 2 = inner second level, 3 = root). A sample taken at that same edge still uses the old threshold.
- R7: After reset, `out_bit` and `out_valid` are 0 and all four thresholds are 128.
- R8: `out_bit` shows the tree result of the inputs sampled at the previous rising edge with `in_valid` high, and `out_valid` equals `in_valid` delayed by one cycle.
- R9: While `in_valid` is 0, `out_bit` keeps its last value whatever the data, sign and random inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Current data bits are a stream sample |
| data_bits | input | 7 | One bit of each tap's data stream, tap k on bit k |
| sign_bits | input | 7 | Coefficient sign per tap, 1 = negative |
| rnd_words | input | 32 | Four 8-bit random words, word k on bits 8k+7:8k |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_idx | input | 2 | Threshold selected for writing |
| thr_wr_val | input | 9 | Threshold value, 0 to 256 |
| out_bit | output | 1 | Registered output stream bit |
| out_valid | output | 1 | Registered valid for out_bit |

## Verification
A threshold write and a valid stream sample can land on the same clock edge. The risk is that the new threshold leaks into the sample being registered. The bench sets up a route to tap 0 with the root threshold at 256. In the same cycle it writes 0 to the root threshold and presents a valid sample, with tap 0 at 1 and the centre tap at 0. The registered bit must still show tap 0, and the sample on the next edge must switch to the centre tap.

// File: rtl/sc_ip_pkg.sv
`timescale 1ns/1ps
package sc_ip_pkg;
  localparam int PREC      = 8;
  localparam int RND_W     = PREC;
  localparam int THR_W     = PREC + 1;
  localparam int NUM_TAPS  = 7;
  localparam int NUM_SEL   = 4;
  localparam int SEL_IDX_W = $clog2(NUM_SEL);
  localparam int RND_BUS_W = NUM_SEL * RND_W;
  localparam logic [THR_W-1:0] THR_RESET = THR_W'(1) << (PREC - 1);

  typedef enum logic [SEL_IDX_W-1:0] {
    SEL_PAIR  = 2'd0,
    SEL_OUTER = 2'd1,
    SEL_INNER = 2'd2,
    SEL_ROOT  = 2'd3
  } sel_id_e;

  typedef logic [NUM_SEL-1:0][THR_W-1:0] thr_bank_t;
endpackage

// File: rtl/sc_rst_sync.sv
`timescale 1ns/1ps
module sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sc_thr_bank.sv
`timescale 1ns/1ps
module sc_thr_bank
  import sc_ip_pkg::*;
#(
  parameter int N_ENT = NUM_SEL,
  parameter int VAL_W = THR_W,
  parameter logic [VAL_W-1:0] RST_VAL = THR_RESET
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(N_ENT)-1:0]       wr_idx,
  input  logic [VAL_W-1:0]               wr_val,
  output logic [N_ENT-1:0][VAL_W-1:0]    thr_q
);
  logic [N_ENT-1:0] ent_en;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    logic [VAL_W-1:0] ent_d;

    always_comb begin
      ent_en[k] = wr_en && (wr_idx == k[$clog2(N_ENT)-1:0]);
      ent_d     = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q[k] <= RST_VAL;
      else if (ent_en[k]) thr_q[k] <= ent_d;
    end
  end
endmodule

// File: rtl/sc_sel_gen.sv
`timescale 1ns/1ps
module sc_sel_gen
  import sc_ip_pkg::*;
#(
  parameter int N_SEL  = NUM_SEL,
  parameter int WORD_W = RND_W,
  parameter int LIM_W  = THR_W
) (
  input  logic [N_SEL*WORD_W-1:0]       rnd_words,
  input  logic [N_SEL-1:0][LIM_W-1:0]   thr,
  output logic [N_SEL-1:0]              sel
);
  localparam int PAD_W = LIM_W - WORD_W;

  for (genvar k = 0; k < N_SEL; k++) begin : g_cmp
    logic [LIM_W-1:0] word_ext;
    always_comb begin
      word_ext = {{PAD_W{1'b0}}, rnd_words[k*WORD_W +: WORD_W]};
      sel[k]   = (word_ext < thr[k]);
    end
  end
endmodule

// File: rtl/sc_mux_tree.sv
`timescale 1ns/1ps
module sc_mux_tree
  import sc_ip_pkg::*;
#(
  parameter int TAPS = NUM_TAPS
) (
  input  logic [TAPS-1:0]    data_bits,
  input  logic [TAPS-1:0]    sign_bits,
  input  logic [NUM_SEL-1:0] sel,
  output logic               root_bit
);
  localparam int HALF = TAPS / 2;

  logic [TAPS-1:0] signed_bits;
  logic [HALF-1:0] pair_bits;
  logic            centre_bit;
  logic            outer_bit;
  logic            inner_bit;

  always_comb begin
    signed_bits = data_bits ^ sign_bits;
    centre_bit  = signed_bits[HALF];
  end

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    always_comb begin
      pair_bits[i] = sel[SEL_PAIR] ? signed_bits[i] : signed_bits[TAPS-1-i];
    end
  end

  always_comb begin
    outer_bit = sel[SEL_OUTER] ? pair_bits[0] : pair_bits[1];
    inner_bit = sel[SEL_INNER] ? pair_bits[2] : centre_bit;
    root_bit  = sel[SEL_ROOT]  ? outer_bit    : inner_bit;
  end
endmodule

// File: rtl/sc_pair_tree_ip.sv
`timescale 1ns/1ps
module sc_pair_tree_ip
  import sc_ip_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NUM_TAPS-1:0]  data_bits,
  input  logic [NUM_TAPS-1:0]  sign_bits,
  input  logic [RND_BUS_W-1:0] rnd_words,
  input  logic                 thr_wr_en,
  input  logic [SEL_IDX_W-1:0] thr_wr_idx,
  input  logic [THR_W-1:0]     thr_wr_val,
  output logic                 out_bit,
  output logic                 out_valid
);
  logic         rst_sync_n;
  thr_bank_t    thr_q;
  logic [NUM_SEL-1:0] sel;
  logic         root_bit;
  logic         out_d;
  logic         vld_d;
  logic         out_q;
  logic         vld_q;

  sc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sc_thr_bank #(.N_ENT(NUM_SEL), .VAL_W(THR_W), .RST_VAL(THR_RESET)) u_thr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (thr_wr_en),
    .wr_idx (thr_wr_idx),
    .wr_val (thr_wr_val),
    .thr_q  (thr_q)
  );

  sc_sel_gen #(.N_SEL(NUM_SEL), .WORD_W(RND_W), .LIM_W(THR_W)) u_sel (
    .rnd_words (rnd_words),
    .thr       (thr_q),
    .sel       (sel)
  );

  sc_mux_tree #(.TAPS(NUM_TAPS)) u_tree (
    .data_bits (data_bits),
    .sign_bits (sign_bits),
    .sel       (sel),
    .root_bit  (root_bit)
  );

  always_comb begin
    vld_d = in_valid;
    out_d = out_q;
    if (in_valid) out_d = root_bit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) out_q <= out_d;
    end
  end

  assign out_bit   = out_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/sc_pair_tree_ip_chk.sv
`timescale 1ns/1ps
module sc_pair_tree_ip_chk
  import sc_ip_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [NUM_TAPS-1:0]  data_bits,
  input logic [NUM_TAPS-1:0]  sign_bits,
  input logic                 thr_wr_en,
  input logic [SEL_IDX_W-1:0] thr_wr_idx,
  input logic [THR_W-1:0]     thr_wr_val,
  input thr_bank_t            thr_q,
  input logic                 out_bit,
  input logic                 out_valid
);
  localparam logic [THR_W-1:0] FULL = THR_W'(1) << PREC;

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
  AST_VALID_DROP:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_bit)); // R9
  AST_THR_STORE:    assert property (@(posedge clk) disable iff (!rst_n)
                      thr_wr_en |=> thr_q[$past(thr_wr_idx)] == $past(thr_wr_val)); // R6
  AST_TAP0_ROUTE:   assert property (@(posedge clk) disable iff (!rst_n)
                      (in_valid && thr_q[SEL_PAIR] >= FULL && thr_q[SEL_OUTER] >= FULL && thr_q[SEL_ROOT] >= FULL)
                      |=> out_bit == $past(data_bits[0] ^ sign_bits[0])); // R2
  AST_CENTRE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
                      (in_valid && thr_q[SEL_INNER] == '0 && thr_q[SEL_ROOT] == '0)
                      |=> out_bit == $past(data_bits[3] ^ sign_bits[3])); // R3
  AST_TAP6_ROUTE:   assert property (@(posedge clk) disable iff (!rst_n)
                      (in_valid && thr_q[SEL_PAIR] == '0 && thr_q[SEL_OUTER] >= FULL && thr_q[SEL_ROOT] >= FULL)
                      |=> out_bit == $past(data_bits[6] ^ sign_bits[6])); // R4
endmodule

bind sc_pair_tree_ip sc_pair_tree_ip_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .data_bits  (data_bits),
  .sign_bits  (sign_bits),
  .thr_wr_en  (thr_wr_en),
  .thr_wr_idx (thr_wr_idx),
  .thr_wr_val (thr_wr_val),
  .thr_q      (thr_q),
  .out_bit    (out_bit),
  .out_valid  (out_valid)
);

// File: tb/sc_pair_tree_ip_test.sv
`timescale 1ns/1ps
module sc_pair_tree_ip_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [6:0]  data_bits;
  logic [6:0]  sign_bits;
  logic [31:0] rnd_words;
  logic        thr_wr_en;
  logic [1:0]  thr_wr_idx;
  logic [8:0]  thr_wr_val;
  logic        out_bit;
  logic        out_valid;

  int errors = 0;
  int checks = 0;

  sc_pair_tree_ip uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_bits(data_bits),
    .sign_bits(sign_bits), .rnd_words(rnd_words), .thr_wr_en(thr_wr_en),
    .thr_wr_idx(thr_wr_idx), .thr_wr_val(thr_wr_val),
    .out_bit(out_bit), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_thr(input logic [1:0] idx, input logic [8:0] val);
    in_valid = 1'b0; thr_wr_en = 1'b1; thr_wr_idx = idx; thr_wr_val = val;
    tick();
    thr_wr_en = 1'b0;
  endtask

  task automatic sample(input logic [6:0] d, input logic [6:0] s, input logic [31:0] r);
    in_valid = 1'b1; data_bits = d; sign_bits = s; rnd_words = r;
    tick();
    in_valid = 1'b0;
  endtask

  // Tap reached for given select values, from the pairing rules
  function automatic int route(input logic p, input logic o, input logic i, input logic r);
    if (r) return o ? (p ? 0 : 6) : (p ? 1 : 5);
    return i ? (p ? 2 : 4) : 3;
  endfunction

  task automatic t_reset();
    check("R7 out_bit after reset", out_bit, 1'b0);
    check("R7 out_valid after reset", out_valid, 1'b0);
    sample(7'b0001000, 7'b0, 32'h7F7F7F7F);   // 127 < 128: all selects 1 -> tap 0
    check("R7 default thr 128, word 127", out_bit, 1'b0);
    sample(7'b0001000, 7'b0, 32'h80808080);   // 128 not < 128 -> centre tap
    check("R7 default thr 128, word 128", out_bit, 1'b1);
  endtask

  task automatic t_routes();
    logic [6:0] dpat [3] = '{7'h55, 7'h2A, 7'h6C};
    logic [6:0] spat [3] = '{7'h0F, 7'h33, 7'h00};
    for (int c = 0; c < 16; c++) begin
      logic p, o, i, r;
      int tap;
      p = c[0]; o = c[1]; i = c[2]; r = c[3];
      write_thr(2'd0, p ? 9'd256 : 9'd0);
      write_thr(2'd1, o ? 9'd256 : 9'd0);
      write_thr(2'd2, i ? 9'd256 : 9'd0);
      write_thr(2'd3, r ? 9'd256 : 9'd0);
      tap = route(p, o, i, r);
      for (int k = 0; k < 3; k++) begin
        sample(dpat[k], spat[k], 32'h5AC3_19E7);
        check($sformatf("R2/R3/R4 route c=%0d tap=%0d", c, tap), out_bit,
              dpat[k][tap] ^ spat[k][tap]);
      end
    end
  endtask

  task automatic t_sign();
    write_thr(2'd0, 9'd256); write_thr(2'd1, 9'd256); write_thr(2'd3, 9'd256);
    sample(7'b0000001, 7'b0000001, 32'h0);
    check("R1 negated tap 0, data 1", out_bit, 1'b0);
    sample(7'b0000000, 7'b0000001, 32'h0);
    check("R1 negated tap 0, data 0", out_bit, 1'b1);
  endtask

  task automatic t_compare();
    int ones = 0;
    write_thr(2'd0, 9'd256); write_thr(2'd1, 9'd256);
    write_thr(2'd2, 9'd0);   write_thr(2'd3, 9'd77);
    for (int v = 0; v < 256; v++) begin
      sample(7'b0000001, 7'b0, {v[7:0], 24'hFFFFFF});
      ones += int'(out_bit);
      if (v == 76) check("R5 word 76 below thr 77", out_bit, 1'b1);
      if (v == 77) check("R5 word 77 equals thr 77", out_bit, 1'b0);
    end
    checks++;
    if (ones != 77) begin
      errors++;
      $display("FAIL R5 ones over sweep: actual=%0d expected=77", ones);
    end
    write_thr(2'd3, 9'd255);
    sample(7'b0000001, 7'b0, 32'hFE000000);
    check("R5 thr 255, word 254", out_bit, 1'b1);
    sample(7'b0000001, 7'b0, 32'hFF000000);
    check("R5 thr 255, word 255", out_bit, 1'b0);
  endtask

  task automatic t_valid_idle();
    write_thr(2'd0, 9'd256); write_thr(2'd1, 9'd256); write_thr(2'd3, 9'd256);
    sample(7'b0000001, 7'b0, 32'h0);
    check("R8 out_valid one cycle after sample", out_valid, 1'b1);
    check("R8 out_bit one cycle after sample", out_bit, 1'b1);
    in_valid = 1'b0; data_bits = 7'b0; sign_bits = 7'b0; rnd_words = 32'hFFFFFFFF;
    tick();
    check("R8 out_valid low when idle", out_valid, 1'b0);
    check("R9 out_bit held when idle", out_bit, 1'b1);
    data_bits = 7'h7E; sign_bits = 7'h01;
    tick();
    check("R9 out_bit still held", out_bit, 1'b1);
  endtask

  task automatic t_write_collide();
    write_thr(2'd0, 9'd256); write_thr(2'd1, 9'd256);
    write_thr(2'd2, 9'd0);   write_thr(2'd3, 9'd256);
    in_valid = 1'b1; data_bits = 7'b0000001; sign_bits = 7'b0; rnd_words = 32'h0;
    thr_wr_en = 1'b1; thr_wr_idx = 2'd3; thr_wr_val = 9'd0;
    tick();
    thr_wr_en = 1'b0;
    check("R6 same-edge write keeps old root thr", out_bit, 1'b1);
    tick();
    in_valid = 1'b0;
    check("R6 new root thr applies next edge", out_bit, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; data_bits = '0; sign_bits = '0;
    rnd_words = '0; thr_wr_en = 1'b0; thr_wr_idx = '0; thr_wr_val = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_routes();
    t_sign();
    t_compare();
    t_valid_idle();
    t_write_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule